// File: doc/BRIEF.md
# Serial two-wire byte memory slave with page buffer

This block is a two-wire bus slave that stands in for a small nonvolatile byte memory of 256 locations, held in an internal array. It watches oversampled clock and data lines, brings both through synchronising flip-flops, and recognises start and stop conditions. It pulls the data line low through a single open-drain enable. A transaction opens with a control byte that carries a fixed device tag and a direction bit. A write then carries a word address and up to one page of data. A read streams bytes from an internal address pointer.

Written bytes first go into an 8-byte page buffer. Nothing reaches the array until the master ends the transfer with a stop. A timed busy period then follows, measured in clock cycles. During that period the slave refuses its control byte, so a master can poll until the write has finished. When it drives read data, the slave waits a configurable number of clocks after each falling clock edge before it changes the data line. This keeps data from moving near the clock edge and producing a false start or stop.

Top module: `i2c_nvmem_slave`

## Requirements
- R1: After reset the SDA enable is low, no write is in progress, the address pointer is 0, and every array byte reads 0xFF.
- R2: A start is SDA falling while the synchronised SCL stays high, and a stop is SDA rising while SCL stays high. A start at any point, including in the middle of a byte, drops the current transfer and releases SDA, and the next 8 bits are taken as a new control byte.
- R3: A control byte is sent MSB first. It is acknowledged (SDA pulled low in the ninth clock) only when bits 7:4 equal 1010. Bits 3:1 are ignored. Bit 0 selects read (1) or write (0). Any other tag gets no acknowledge, and the slave then ignores the bus until the next start.
- R4: After a write control byte, the next byte is the word address and the bytes after it are data. The slave acknowledges each of them.
- R5: Each data byte goes into the page buffer at the slot given by pointer bits 2:0. Only those three bits then advance, wrapping 7 to 0 while bits 7:3 stay fixed. More than eight bytes overwrite the earlier slots.
- R6: The array is unchanged until a stop. Only a stop that follows at least one complete data byte starts a commit. A repeated start does not commit, and neither does a transfer cut off before its first full data byte.
- R7: A commit keeps the slave busy for exactly WR_CYCLES clocks and writes the buffered bytes at the end. While busy, every control byte is not acknowledged. Once busy ends, control bytes are acknowledged again.
- R8: A random read (write control byte, word address, repeated start, read control byte) returns the byte at that word address.
- R9: In a read, the pointer advances by one after every byte sent, wrapping from 255 to 0. A master acknowledge brings the next byte, and a master no-acknowledge ends the read.
- R10: A read control byte with no address phase (current-address read) starts at the pointer left by the previous transfer.
- R11: SDA output changes only while SCL is low. Each change comes HOLD_CYCLES clocks after the synchronised SCL fall is detected, so SYNC_STAGES+1+HOLD_CYCLES clocks after SCL falls at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench builds the block with WR_CYCLES=1000 and HOLD_CYCLES=4, keeping SYNC_STAGES=2 and PAGE_BITS=3. With a 1000-clock write time, a poll that starts just after a stop lands inside the busy window, and a wait of a little over 1000 clocks is enough to see acknowledges return. A 4-clock hold fits well inside the bench's 20-clock SCL low phase, so the exact SCL-fall-to-SDA delay can be measured as a single number. With these values, a page write that wraps, a commit deferred across a repeated start, and a read that wraps past address 255 all run within a few tens of thousands of cycles.

// File: rtl/i2c_nvmem_pkg.sv
`timescale 1ns/1ps
package i2c_nvmem_pkg;

  localparam int ADDR_W = 8;
  localparam logic [3:0] DEV_TAG = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } slv_state_t;

  // advance only the in-page bits, keep the page number
  function automatic logic [ADDR_W-1:0] page_step(logic [ADDR_W-1:0] a, int unsigned pb);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'((1 << pb) - 1);
    return (a & ~m) | ((a + 1'b1) & m);
  endfunction

  // full pointer advance for reads, natural wrap at the top
  function automatic logic [ADDR_W-1:0] seq_step(logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic tag_match(logic [7:0] b);
    return b[7:4] == DEV_TAG;
  endfunction

endpackage

// File: rtl/i2c_nvmem_sync.sv
`timescale 1ns/1ps
module i2c_nvmem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_nvmem_hold.sv
`timescale 1ns/1ps
module i2c_nvmem_hold #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall,
  output logic fall_evt
);
  generate
    if (HOLD == 0) begin : g_direct
      assign fall_evt = scl_fall;
    end else begin : g_count
      localparam int CW = $clog2(HOLD + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (scl_fall)      cnt <= CW'(HOLD);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
      end
      assign fall_evt = (cnt == CW'(1));
    end
  endgenerate
endmodule

// File: rtl/i2c_nvmem_store.sv
`timescale 1ns/1ps
module i2c_nvmem_store
  import i2c_nvmem_pkg::*;
#(
  parameter int WR_CYCLES = 1000,
  parameter int PAGE_BITS = 3,
  parameter logic [7:0] ERASED = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_we,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_data,
  input  logic              commit_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              commit_done
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_BITS;
  localparam int BASE_W = ADDR_W - PAGE_BITS;
  localparam int CW     = $clog2(WR_CYCLES + 1);

  logic [7:0]        mem   [DEPTH];
  logic [7:0]        pbuf  [PAGE_N];
  logic [PAGE_N-1:0] pvalid;
  logic [BASE_W-1:0] pbase;
  logic [CW-1:0]     timer;
  logic              pending;

  assign pending     = |pvalid;
  assign commit_done = busy && (timer == CW'(1));
  assign rd_data     = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      timer <= '0;
    end else if (commit_req && pending && !busy) begin
      busy  <= 1'b1;
      timer <= CW'(WR_CYCLES);
    end else if (busy) begin
      timer <= timer - 1'b1;
      if (commit_done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pvalid <= '0;
      pbase  <= '0;
      for (int p = 0; p < PAGE_N; p++) pbuf[p] <= 8'h00;
    end else if (commit_done) begin
      pvalid <= '0;
    end else if (buf_we) begin
      pbuf[buf_addr[PAGE_BITS-1:0]]   <= buf_data;
      pvalid[buf_addr[PAGE_BITS-1:0]] <= 1'b1;
      pbase <= buf_addr[ADDR_W-1:PAGE_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (commit_done) begin
      for (int p = 0; p < PAGE_N; p++)
        if (pvalid[p]) mem[{pbase, PAGE_BITS'(p)}] <= pbuf[p];
    end
  end
endmodule

// File: rtl/i2c_nvmem_slave.sv
`timescale 1ns/1ps
module i2c_nvmem_slave
  import i2c_nvmem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 6,
  parameter int WR_CYCLES   = 2000000,
  parameter int PAGE_BITS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam logic [3:0] BIT_LAST = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, fall_evt;
  logic busy, commit_done;
  logic [7:0] rd_data;

  slv_state_t        state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, txreg;
  logic [ADDR_W-1:0] ptr;
  logic              rw_q, mack;

  // named events for the checker
  logic byte_in_done, ctrl_ok, ctrl_ack_evt, buf_we, rx_phase;

  i2c_nvmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_nvmem_hold #(.HOLD(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .fall_evt(fall_evt)
  );

  i2c_nvmem_store #(.WR_CYCLES(WR_CYCLES), .PAGE_BITS(PAGE_BITS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .buf_we(buf_we), .buf_addr(ptr), .buf_data(shreg),
    .commit_req(stop_det),
    .rd_addr(ptr), .rd_data(rd_data),
    .busy(busy), .commit_done(commit_done)
  );

  assign rx_phase     = (state == ST_CTRL) || (state == ST_ADDR) || (state == ST_WDATA);
  assign byte_in_done = fall_evt && (bitcnt == BIT_LAST);
  assign ctrl_ok      = tag_match(shreg) && !busy;
  assign ctrl_ack_evt = byte_in_done && (state == ST_CTRL) && ctrl_ok;
  assign buf_we       = byte_in_done && (state == ST_WDATA) && !start_det && !stop_det;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      ptr      <= '0;
      rw_q     <= 1'b0;
      mack     <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state    <= ST_CTRL;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      if (scl_rise && rx_phase && bitcnt != BIT_LAST) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end
      if (scl_rise && state == ST_RACK) mack <= ~sda_s;
      if (fall_evt) begin
        case (state)
          ST_CTRL: if (bitcnt == BIT_LAST) begin
            if (ctrl_ok) begin
              sda_oe_o <= 1'b1;
              rw_q     <= shreg[0];
              state    <= ST_CTRL_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ADDR: if (bitcnt == BIT_LAST) begin
            ptr      <= shreg;
            sda_oe_o <= 1'b1;
            state    <= ST_ADDR_ACK;
          end
          ST_WDATA: if (bitcnt == BIT_LAST) begin
            ptr      <= page_step(ptr, PAGE_BITS);
            sda_oe_o <= 1'b1;
            state    <= ST_WDATA_ACK;
          end
          ST_CTRL_ACK: begin
            if (rw_q) begin
              txreg    <= {rd_data[6:0], 1'b0};
              sda_oe_o <= ~rd_data[7];
              bitcnt   <= 4'd1;
              state    <= ST_RDATA;
            end else begin
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
              state    <= ST_ADDR;
            end
          end
          ST_ADDR_ACK, ST_WDATA_ACK: begin
            sda_oe_o <= 1'b0;
            bitcnt   <= '0;
            state    <= ST_WDATA;
          end
          ST_RDATA: begin
            if (bitcnt == BIT_LAST) begin
              sda_oe_o <= 1'b0;
              ptr      <= seq_step(ptr);
              state    <= ST_RACK;
            end else begin
              sda_oe_o <= ~txreg[7];
              txreg    <= {txreg[6:0], 1'b0};
              bitcnt   <= bitcnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (mack) begin
              txreg    <= {rd_data[6:0], 1'b0};
              sda_oe_o <= ~rd_data[7];
              bitcnt   <= 4'd1;
              state    <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_nvmem_chk.sv
`timescale 1ns/1ps
module i2c_nvmem_chk
  import i2c_nvmem_pkg::*;
#(
  parameter int WR_CYCLES = 1000,
  parameter int PAGE_BITS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              start_det,
  input logic              stop_det,
  input logic              busy,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr
);
  int unsigned busy_len;
  logic        page_seen;
  logic [ADDR_W-PAGE_BITS-1:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_len  <= 0;
      page_seen <= 1'b0;
      page_q    <= '0;
    end else begin
      busy_len <= busy ? busy_len + 1 : 0;
      if (start_det) page_seen <= 1'b0;
      else if (buf_we) begin
        page_seen <= 1'b1;
        page_q    <= buf_addr[ADDR_W-1:PAGE_BITS];
      end
    end
  end

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe); // R2

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && page_seen) |-> (buf_addr[ADDR_W-1:PAGE_BITS] == page_q)); // R5

  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det)); // R6

  AST_WRITE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == WR_CYCLES)); // R7

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R11
endmodule

bind i2c_nvmem_slave i2c_nvmem_chk #(.WR_CYCLES(WR_CYCLES), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .start_det(start_det), .stop_det(stop_det), .busy(busy),
  .buf_we(buf_we), .buf_addr(ptr)
);

// File: tb/i2c_nvmem_slave_tb.sv
`timescale 1ns/1ps
module i2c_nvmem_slave_tb;
  localparam int WR_CYC = 1000;
  localparam int HOLD   = 4;
  localparam int T      = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_nvmem_slave #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .WR_CYCLES(WR_CYC), .PAGE_BITS(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  int total = 0, bad = 0, cyc = 0, oe_glitch = 0, last_delay = 0;
  int model_mem [256];
  int mptr = 0;
  int pend_a[$], pend_d[$];
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // per-clock monitor: the slave never moves SDA while SCL is high (R11)
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe)) oe_glitch++;
    prev_scl <= scl_m;
    prev_oe  <= sda_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic m_start();
    sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T); sda_m = 1'b0; tick(T); scl_m = 1'b0; tick(2);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tick(T); scl_m = 1'b1; tick(T); sda_m = 1'b1; tick(T);
    foreach (pend_a[i]) model_mem[pend_a[i]] = pend_d[i];
    pend_a.delete(); pend_d.delete();
  endtask

  task automatic m_bit_w(int b);
    sda_m = b[0]; tick(T); scl_m = 1'b1; tick(T); scl_m = 1'b0; tick(2);
  endtask

  task automatic m_bit_r(output int v);
    sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T/2); v = sda_bus; tick(T/2); scl_m = 1'b0; tick(2);
  endtask

  task automatic m_byte_w(int b, output int ack);
    int v, n;
    for (int i = 7; i >= 0; i--) m_bit_w((b >> i) & 1);
    n = 2;
    while (!sda_oe && n < T) begin tick(1); n++; end
    last_delay = n;
    m_bit_r(v);
    ack = (v == 0);
  endtask

  task automatic m_byte_r(int ack_it, output int b);
    int v;
    b = 0;
    for (int i = 0; i < 8; i++) begin m_bit_r(v); b = (b << 1) | v; end
    m_bit_w(ack_it ? 0 : 1);
  endtask

  task automatic txn_write(int addr, int data[$], bit do_stop);
    int ack, base, off;
    m_start();
    m_byte_w(8'hA0, ack); chk("R3 write ctrl ack", ack, 1);
    m_byte_w(addr, ack);  chk("R4 addr ack", ack, 1);
    base = addr & 8'hF8; off = addr & 7;
    foreach (data[i]) begin
      m_byte_w(data[i], ack); chk("R4 data ack", ack, 1);
      pend_a.push_back(base + off); pend_d.push_back(data[i]);
      off = (off + 1) % 8;
    end
    mptr = base + off;
    if (do_stop) m_stop();
  endtask

  task automatic rand_read(int addr, int n, string req);
    int ack, b;
    m_start();
    m_byte_w(8'hA0, ack); chk("R8 ctrl ack", ack, 1);
    m_byte_w(addr, ack);  chk("R8 addr ack", ack, 1);
    m_start();
    m_byte_w(8'hA1, ack); chk("R8 read ctrl ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      m_byte_r(i != n - 1, b);
      chk(req, b, model_mem[(addr + i) % 256]);
    end
    mptr = (addr + n) % 256;
    m_stop();
  endtask

  task automatic cur_read(int ctrl, string req);
    int ack, b;
    m_start();
    m_byte_w(ctrl, ack); chk("R3 read ctrl ack", ack, 1);
    m_byte_r(0, b);
    chk(req, b, model_mem[mptr]);
    mptr = (mptr + 1) % 256;
    m_stop();
  endtask

  task automatic poll(int exp_ack, string req);
    int ack;
    m_start();
    m_byte_w(8'hA0, ack);
    chk(req, ack, exp_ack);
    m_stop();
  endtask

  initial begin
    int ack;
    int pg[$];
    for (int i = 0; i < 256; i++) model_mem[i] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R1 sda released after reset", sda_oe, 0);

    cur_read(8'hA1, "R1 R10 erased byte at pointer 0");
    rand_read(8'h10, 1, "R1 erased byte");

    txn_write(8'h23, '{8'h5A}, 1'b1);
    chk("R11 ack delay after SCL fall", last_delay, HOLD + 3);
    poll(0, "R7 no ack while busy");
    tick(WR_CYC + 100);
    poll(1, "R7 ack after busy");
    rand_read(8'h23, 1, "R8 random read of written byte");

    m_start();
    m_byte_w(8'hB0, ack); chk("R3 wrong tag not acked", ack, 0);
    chk("R3 sda released after wrong tag", sda_oe, 0);
    m_stop();
    cur_read(8'hAF, "R3 R10 ignored bits, current read");

    pg = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17, 8'h18, 8'h19};
    txn_write(8'h45, pg, 1'b0);
    rand_read(8'h45, 1, "R6 array unchanged before stop");
    poll(0, "R7 busy after page commit");
    tick(WR_CYC + 100);
    rand_read(8'h40, 8, "R5 R9 page wrap contents");
    chk("R5 overwritten slot", model_mem[8'h45], 8'h18);

    txn_write(8'hFF, '{8'h11}, 1'b1);
    tick(WR_CYC + 100);
    txn_write(8'h00, '{8'h22, 8'h33}, 1'b1);
    tick(WR_CYC + 100);
    rand_read(8'hFE, 3, "R9 sequential wrap 255 to 0");
    cur_read(8'hA1, "R10 current read after wrap");

    m_start();
    m_byte_w(8'hA0, ack); chk("R2 ctrl ack", ack, 1);
    m_byte_w(8'h70, ack); chk("R2 addr ack", ack, 1);
    for (int i = 0; i < 4; i++) m_bit_w(0);
    m_start();
    m_byte_w(8'hA0, ack); chk("R2 R6 start mid-byte: ctrl acked, not busy", ack, 1);
    m_stop();
    rand_read(8'h70, 1, "R2 R6 cut-off byte not stored");

    chk("R11 sda changes while SCL high", oe_glitch, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule